// File: doc/BRIEF.md
# Critical-Traffic Switch Usage Monitor

This block sits beside the crossbar of a small router and learns which path each input port most often takes for latency-sensitive traffic. Every packet that crosses the switch is reported by a one-cycle strobe that carries the input and output port indices. A companion flag marks the packet as belonging to one of the few threads currently judged most critical. Only flagged packets are counted. There is one saturating counter for each input/output pair.

A programmable cycle counter divides time into monitoring intervals. On the last cycle of each interval, the block picks for every input the output with the largest count. It writes those choices into a preserved port mapping that steers the crossbar's bypass path, pulses a one-cycle load strobe, and restarts all counters. Each mapping therefore describes only the interval that just ended. Criticality prediction happens elsewhere; the flag arrives ready-made.

Top module: `sw_usage_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, `tbl_load` is 0 and mapping entry i (bits `[i*IDX_W +: IDX_W]` of `tbl_map`) equals i.
- R2: Each cycle with `trav_valid` and `trav_critical` both high adds one to the counter of the pair (`trav_in`, `trav_out`).
- R3: A cycle with `trav_critical` low or `trav_valid` low changes no counter.
- R4: A counter that reaches 2^CNT_W-1 stays there until the next interval boundary.
- R5: An interval boundary falls on every L-th clock edge, where L is `interval_len`, or 2 when `interval_len` is below 2. The first boundary after reset release is on the L-th edge. `tbl_load` is high for exactly the one cycle that follows each boundary edge.
- R6: At a boundary, each input's mapping entry becomes the output with the highest count in the interval that just ended. The new mapping appears in the same cycle that `tbl_load` is high.
- R7: When several outputs share the highest count, the lowest output index wins.
- R8: An input whose counts are all zero at a boundary keeps its previous mapping entry.
- R9: At a boundary all counters restart from zero. A qualifying traversal reported in the boundary cycle itself counts toward the new interval.
- R10: `tbl_map` changes only in cycles where `tbl_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trav_valid | input | 1 | One packet crossed the switch this cycle |
| trav_in | input | IDX_W | Input port index of the traversal |
| trav_out | input | IDX_W | Output port index of the traversal |
| trav_critical | input | 1 | Traversal belongs to a critical thread |
| interval_len | input | IVL_W | Monitoring interval length in cycles |
| tbl_load | output | 1 | One-cycle strobe: new mapping is valid |
| tbl_map | output | NPORTS*IDX_W | Preserved input-to-output mapping, entry i at bits [i*IDX_W +: IDX_W] |

## Verification
The bench loads one input with 256 packets on one output and 300 on another. A counter that wraps instead of saturating would let the second output win, while correct saturation produces a tie that the lower index breaks. Ties are also checked at small counts, so a design using `>=` in its comparison would pick the higher output.

An interval with no traffic must leave the mapping as it was. A later interval with a single packet must then win, which shows up counters that are not cleared, or that reset the entry to zero instead of keeping it. A traversal placed exactly on a boundary cycle must show up in the following mapping; a design that drops it would leave that entry unchanged.

Load spacing is measured for a normal length and for a length of 1, and a length that is not floored would pulse every cycle. Non-critical and invalid traffic sent to a different pair must not move any entry.

// File: rtl/swmon_pkg.sv
// Package: shared constants and helpers for the switch usage monitor.
// Assumes: port counts are small (a router radix), so index widths stay narrow.
package swmon_pkg;

    localparam int unsigned DEF_PORTS = 4;
    localparam int unsigned DEF_CNT_W = 8;
    localparam int unsigned DEF_IVL_W = 16;

    // Width of a port index; a single-port switch still gets one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/swmon_interval_timer.sv
// Module: swmon_interval_timer
// Marks the last cycle of each monitoring interval with a combinational
// boundary flag. The interval length is read live, and values below 2 act as 2
// so that the load strobe that follows a boundary is always a single cycle.
// Assumes: a synchronous active-low reset restarts the interval.
module swmon_interval_timer #(
    parameter int unsigned IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] interval_len,
    output logic             boundary
);

    logic [IVL_W-1:0] tick_q;
    logic [IVL_W-1:0] last_tick;

    // Purpose: index of the final cycle in the interval, with length floored at 2.
    always_comb begin
        if (interval_len < IVL_W'(2)) begin
            last_tick = IVL_W'(1);
        end else begin
            last_tick = interval_len - IVL_W'(1);
        end
    end

    // Purpose: flag the final cycle; >= also covers a length shortened mid-interval.
    assign boundary = (tick_q >= last_tick);

    // Purpose: count cycles within the interval and wrap at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (boundary) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + IVL_W'(1);
        end
    end

endmodule

// File: rtl/swmon_pair_counters.sv
// Module: swmon_pair_counters
// Holds NPORTS x NPORTS saturating counters, one per input/output pair. Counter
// (i,o) sits at bits [(i*NPORTS+o)*CNT_W +: CNT_W] of the flat output.
// On clear, each counter restarts at 0, or at 1 if it is the pair hit in
// that same cycle.
// Assumes: hit_valid is already qualified by criticality; out-of-range
// indices match no counter.
module swmon_pair_counters #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned IDX_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             hit_valid,
    input  logic [IDX_W-1:0]                 hit_in,
    input  logic [IDX_W-1:0]                 hit_out,
    input  logic                             clear,
    output logic [NPORTS*NPORTS*CNT_W-1:0]   counts
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_in
        for (genvar go = 0; go < NPORTS; go++) begin : g_out
            logic             sel;
            logic [CNT_W-1:0] cnt_q;

            // Purpose: decode whether this pair is the one traversed this cycle.
            assign sel = hit_valid
                      && (hit_in  == IDX_W'(gi))
                      && (hit_out == IDX_W'(go));

            // Purpose: saturating count, restarted at each interval boundary.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clear) begin
                    cnt_q <= sel ? CNT_W'(1) : '0;
                end else if (sel && (cnt_q != CNT_MAX)) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end

            assign counts[(gi*NPORTS+go)*CNT_W +: CNT_W] = cnt_q;
        end
    end

endmodule

// File: rtl/swmon_argmax_row.sv
// Module: swmon_argmax_row
// Combinational selection of the most-used output for one input row.
// The strict comparison keeps the lowest index on ties. A row of all zeros
// returns the previous selection unchanged.
// Assumes: row packs NPORTS counters, output o at bits [o*CNT_W +: CNT_W].
module swmon_argmax_row #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [NPORTS*CNT_W-1:0] row,
    input  logic [IDX_W-1:0]        prev_sel,
    output logic [IDX_W-1:0]        new_sel
);

    logic [CNT_W-1:0] best_cnt;
    logic [IDX_W-1:0] best_idx;

    // Purpose: linear scan for the largest count, lowest index first.
    always_comb begin
        best_cnt = row[CNT_W-1:0];
        best_idx = '0;
        for (int o = 1; o < NPORTS; o++) begin
            if (row[o*CNT_W +: CNT_W] > best_cnt) begin
                best_cnt = row[o*CNT_W +: CNT_W];
                best_idx = IDX_W'(o);
            end
        end
    end

    // Purpose: keep the old entry when this input saw no critical traffic.
    assign new_sel = (best_cnt == '0) ? prev_sel : best_idx;

endmodule

// File: rtl/sw_usage_monitor.sv
// Module: sw_usage_monitor (top)
// Counts critical-thread switch traversals per input/output pair. At every
// interval boundary it rebuilds the preserved port mapping from the
// per-input argmax and pulses tbl_load for one cycle; the mapping changes
// in that same cycle.
// Assumes: one traversal report per cycle at most; the criticality flag is
// produced upstream.
module sw_usage_monitor #(
    parameter int unsigned NPORTS = swmon_pkg::DEF_PORTS,
    parameter int unsigned CNT_W  = swmon_pkg::DEF_CNT_W,
    parameter int unsigned IVL_W  = swmon_pkg::DEF_IVL_W,
    localparam int unsigned IDX_W = swmon_pkg::idx_width(NPORTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trav_valid,
    input  logic [IDX_W-1:0]        trav_in,
    input  logic [IDX_W-1:0]        trav_out,
    input  logic                    trav_critical,
    input  logic [IVL_W-1:0]        interval_len,
    output logic                    tbl_load,
    output logic [NPORTS*IDX_W-1:0] tbl_map
);

    localparam int unsigned ROW_W = NPORTS * CNT_W;

    logic                           boundary;
    logic                           crit_hit;
    logic [NPORTS*NPORTS*CNT_W-1:0] pair_counts;
    logic                           load_q;

    // Purpose: only critical-thread traversals reach the counters.
    assign crit_hit = trav_valid && trav_critical;

    swmon_interval_timer #(
        .IVL_W        (IVL_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .interval_len (interval_len),
        .boundary     (boundary)
    );

    swmon_pair_counters #(
        .NPORTS    (NPORTS),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (crit_hit),
        .hit_in    (trav_in),
        .hit_out   (trav_out),
        .clear     (boundary),
        .counts    (pair_counts)
    );

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_row
        logic [IDX_W-1:0] map_q;
        logic [IDX_W-1:0] next_sel;

        swmon_argmax_row #(
            .NPORTS   (NPORTS),
            .CNT_W    (CNT_W),
            .IDX_W    (IDX_W)
        ) u_argmax (
            .row      (pair_counts[gi*ROW_W +: ROW_W]),
            .prev_sel (map_q),
            .new_sel  (next_sel)
        );

        // Purpose: mapping entry; identity after reset, rewritten at each boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q <= IDX_W'(gi);
            end else if (boundary) begin
                map_q <= next_sel;
            end
        end

        assign tbl_map[gi*IDX_W +: IDX_W] = map_q;
    end

    // Purpose: one-cycle load strobe aligned with the new mapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
        end else begin
            load_q <= boundary;
        end
    end

    assign tbl_load = load_q;

endmodule

// File: rtl/sw_usage_monitor_chk.sv
// Module: sw_usage_monitor_chk
// Property checker bound to sw_usage_monitor. It observes ports plus the
// internal boundary flag and the pair counters.
module sw_usage_monitor_chk #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned IDX_W  = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           trav_valid,
    input logic                           trav_critical,
    input logic                           boundary,
    input logic                           tbl_load,
    input logic [NPORTS*IDX_W-1:0]        tbl_map,
    input logic [NPORTS*NPORTS*CNT_W-1:0] counts
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic past_ok;

    // Purpose: mark that at least one clock has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R5: the load strobe never lasts two cycles.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_load |=> !tbl_load);

    // R10: the mapping holds outside load cycles.
    a_r10_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !tbl_load) |-> (tbl_map == $past(tbl_map)));

    // R3: non-qualifying cycles away from a boundary leave every counter alone.
    a_r3_ignore_noncrit: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !(trav_valid && trav_critical)) |=> $stable(counts));

    // R9: after a boundary at most one counter is nonzero, and it holds 1.
    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> ($countones(counts) <= 1));

    for (genvar k = 0; k < NPORTS*NPORTS; k++) begin : g_sat
        // R4: a full counter does not wrap before the boundary.
        a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            ((counts[k*CNT_W +: CNT_W] == CNT_MAX) && !boundary)
            |=> (counts[k*CNT_W +: CNT_W] == CNT_MAX));
    end

endmodule

bind sw_usage_monitor sw_usage_monitor_chk #(
    .NPORTS        (NPORTS),
    .CNT_W         (CNT_W),
    .IDX_W         (IDX_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .trav_valid    (trav_valid),
    .trav_critical (trav_critical),
    .boundary      (boundary),
    .tbl_load      (tbl_load),
    .tbl_map       (tbl_map),
    .counts        (pair_counts)
);

// File: tb/sw_usage_monitor_tb_top.sv
// Directed bench for sw_usage_monitor: one task per scenario, each checking itself.
module sw_usage_monitor_tb_top;

    localparam int unsigned NPORTS = 4;
    localparam int unsigned IDX_W  = 2;
    localparam int unsigned IVL_W  = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    trav_valid = 1'b0;
    logic [IDX_W-1:0]        trav_in = '0;
    logic [IDX_W-1:0]        trav_out = '0;
    logic                    trav_critical = 1'b0;
    logic [IVL_W-1:0]        interval_len = 16'd64;
    logic                    tbl_load;
    logic [NPORTS*IDX_W-1:0] tbl_map;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sw_usage_monitor #(.NPORTS(NPORTS), .CNT_W(8), .IVL_W(IVL_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trav_valid    (trav_valid),
        .trav_in       (trav_in),
        .trav_out      (trav_out),
        .trav_critical (trav_critical),
        .interval_len  (interval_len),
        .tbl_load      (tbl_load),
        .tbl_map       (tbl_map)
    );

    function automatic int ent(input int i);
        return int'(tbl_map[i*IDX_W +: IDX_W]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset with a given interval; returns just after the release negedge.
    task automatic do_reset(input int len);
        @(negedge clk);
        rst_n = 1'b0; trav_valid = 1'b0; trav_critical = 1'b0;
        interval_len = IVL_W'(len);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive n consecutive traversal cycles, one per clock edge.
    task automatic pkt(input int i, input int o, input bit crit, input int n);
        for (int k = 0; k < n; k++) begin
            trav_valid = 1'b1; trav_in = IDX_W'(i); trav_out = IDX_W'(o);
            trav_critical = crit;
            @(negedge clk);
        end
        trav_valid = 1'b0; trav_critical = 1'b0;
    endtask

    // Step until tbl_load is seen high; cyc counts negedges taken.
    task automatic wait_load(input string req, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!tbl_load && cyc < 5000);
        if (!tbl_load) begin
            checks++; fails++;
            $display("FAIL %s actual=timeout expected=tbl_load", req);
        end
    endtask

    task automatic t_reset();
        do_reset(64);
        chk("R1 load low", int'(tbl_load), 0);
        for (int i = 0; i < 4; i++) chk("R1 identity map", ent(i), i);
    endtask

    task automatic t_basic();
        int c;
        do_reset(64);
        pkt(0, 2, 1, 3); pkt(0, 1, 1, 1);       // R2 in0 -> 2
        pkt(1, 3, 1, 2);                        // in1 -> 3
        pkt(3, 0, 1, 1);                        // in3 -> 0
        pkt(2, 1, 0, 5);                        // R3 non-critical ignored
        trav_critical = 1'b1; trav_in = 2'd2; trav_out = 2'd3;
        repeat (3) @(negedge clk);              // R3 critical but not valid
        trav_critical = 1'b0;
        wait_load("R6 basic", c);
        chk("R6 in0 argmax", ent(0), 2);
        chk("R6 in1 argmax", ent(1), 3);
        chk("R3 R8 in2 kept", ent(2), 2);
        chk("R2 in3 single packet", ent(3), 0);
    endtask

    task automatic t_ties_and_clear();
        int c;
        do_reset(64);
        pkt(0, 3, 1, 2); pkt(0, 1, 1, 2);
        pkt(1, 2, 1, 1); pkt(1, 0, 1, 1);
        wait_load("R7 tie", c);
        chk("R7 in0 tie lowest", ent(0), 1);
        chk("R7 in1 tie lowest", ent(1), 0);
        wait_load("R8 idle interval", c);
        chk("R8 in0 kept on empty", ent(0), 1);
        pkt(0, 2, 1, 1);
        wait_load("R9 clear", c);
        chk("R9 old counts cleared", ent(0), 2);
    endtask

    task automatic t_period();
        int c;
        do_reset(5);
        wait_load("R5 first", c);
        chk("R5 first load edge", c, 5);
        wait_load("R5 second", c);
        chk("R5 spacing", c, 5);
        @(negedge clk);
        chk("R5 single cycle pulse", int'(tbl_load), 0);
        do_reset(1);
        wait_load("R5 floor", c);
        chk("R5 length 1 acts as 2", c, 2);
        wait_load("R5 floor2", c);
        chk("R5 floor spacing", c, 2);
    endtask

    task automatic t_saturate();
        int c;
        do_reset(1000);
        pkt(0, 1, 1, 256); pkt(0, 2, 1, 300);
        pkt(1, 3, 1, 200); pkt(1, 2, 1, 199);
        wait_load("R4 sat", c);
        chk("R4 saturated tie", ent(0), 1);
        chk("R6 large counts", ent(1), 3);
    endtask

    task automatic t_boundary_hit();
        int c;
        do_reset(8);
        wait_load("R9 sync", c);
        repeat (7) @(negedge clk);
        pkt(3, 1, 1, 1);                        // lands on the boundary edge
        chk("R9 load on boundary", int'(tbl_load), 1);
        chk("R9 entry unchanged yet", ent(3), 3);
        wait_load("R9 carry", c);
        chk("R9 boundary hit counted next", ent(3), 1);
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_ties_and_clear();
        t_period();
        t_saturate();
        t_boundary_hit();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule